// File: doc/BRIEF.md
# Interlaced Video Sync Timing Generator

This block produces the master-side sync outputs for an interlaced video raster. A pixel counter runs across each line and a line counter runs across the frame, which holds two fields. From these counts the block drives three outputs: an active-low horizontal sync, one combined field/vertical-sync pin, and a one-cycle strobe that marks pixel 0 of every line. The strobe is the reference point for the pixel data.

A small host port holds one 8-bit timing byte and one mode bit. The host can write and read both. Each 2-bit field of the byte selects one of four pixel-clock counts, and the steps between these counts are not even. The mode bit decides what the combined pin carries. In field mode it is an active-high field flag, and it can be moved by half a line. In pulse mode it is an active-low vertical sync pulse whose width is programmable. A host write lands in the register at once, but the sync logic only takes the new value at the next line start. Because of this, a pulse is never cut short or stretched.

Line length, frame line count and first-field line count are parameters. The defaults are 1728 clocks per line, 625 lines and 313 lines, which is a 625-line raster at 27 MHz. With these defaults, half a line is 864 clocks.

Top module: `vsync_timing_gen`

## Requirements
- R1: While reset is asserted, hsyncN is 1, fvSync is 0, pixStrobe is 0, and regRdata and regRmode read 0. After the first clock edge with reset low, the outputs show line 1, pixel 0.
- R2: The pixel count runs from 0 to LINE_CLKS-1. The line count runs from 1 to FRAME_LINES and then returns to 1. pixStrobe is 1 for exactly the pixel-0 cycle of every line.
- R3: Timing byte bits [1:0] set the hsyncN low time. Codes 0, 1, 2 and 3 give 1, 4, 16 and 128 clocks.
- R4: Timing byte bits [7:6] set a value A from 0 to 3. hsyncN goes low at pixel A of every line, which is A clocks after pixStrobe.
- R5: Timing byte bits [3:2] add a delay D of 0, 4, 8 or 16 clocks for codes 0 to 3. The field/vsync edge sits at pixel A+D.
- R6: With mode bit 0, fvSync is a field flag. It rises on line 1 at pixel A+D+H and falls on line FIELD_LINES+1 at the same pixel. H is LINE_CLKS/2 when byte bit 4 is 1 and 0 otherwise. Byte bit 5 has no effect in this mode.
- R7: With mode bit 1, fvSync is low only on line 1 and line FIELD_LINES+1. On each of those lines it is low from pixel A+D for 1, 4, 16 or 128 clocks, selected by byte bits [5:4] with codes 0 to 3.
- R8: After a cycle with regWe high, regRdata and regRmode return the written byte and mode bit from the next cycle on. Without a write, they hold their value.
- R9: The sync outputs use the register value as it stood at the last clock of the previous line. A write therefore takes effect from pixel 0 of the next line, and each line uses one setting from start to end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| regWe | input | 1 | Host write enable |
| regWdata | input | 8 | Timing byte to write |
| regWmode | input | 1 | Mode bit to write (0 field flag, 1 vsync pulse) |
| regRdata | output | 8 | Readback of the timing byte |
| regRmode | output | 1 | Readback of the mode bit |
| hsyncN | output | 1 | Horizontal sync, active low |
| fvSync | output | 1 | Field flag (mode 0) or vertical sync, active low (mode 1) |
| pixStrobe | output | 1 | High on the pixel-0 cycle of each line |

## Verification
Every sync output is one register behind the counters. The value seen after clock edge n therefore belongs to raster position n, counted from the first edge after reset. A host write shows on readback after one edge. It reaches the sync outputs only at the first pixel-0 position after the line in which it landed.

The bench samples on the falling clock edge. It keeps its own position count, its own copy of the register and its own latched setting. It updates these copies in the same order as the edges and compares each output with the position that the edge just produced. Random writes land at any pixel, so the line-start take-over rule is checked across many mid-line changes.

// File: rtl/vsg_pkg.sv
package vsg_pkg;

  // Bit positions match the host byte: [7:6] shift, [5:4] field/vsync, [3:2] delay, [1:0] width
  typedef struct packed {
    logic [1:0] dataShift;
    logic [1:0] fieldSel;
    logic [1:0] edgeDelay;
    logic [1:0] hsWidth;
  } timingByte_t;

  typedef struct packed {
    timingByte_t tb;
    logic        vsyncMode;
  } timingCfg_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic lineStart;
    logic firstEdgeLine;
    logic secondEdgeLine;
    logic oddBody;
  } lineStrobes_t;

  function automatic logic [7:0] pulseCodeLen(input logic [1:0] code);
    case (code)
      2'd0:    return 8'd1;
      2'd1:    return 8'd4;
      2'd2:    return 8'd16;
      default: return 8'd128;
    endcase
  endfunction

  function automatic logic [4:0] delayCodeLen(input logic [1:0] code);
    case (code)
      2'd0:    return 5'd0;
      2'd1:    return 5'd4;
      2'd2:    return 5'd8;
      default: return 5'd16;
    endcase
  endfunction

endpackage

// File: rtl/vsg_ctrl.sv
module vsg_ctrl
  import vsg_pkg::*;
#(
  parameter int LINE_CLKS   = 1728,
  parameter int FRAME_LINES = 625,
  parameter int FIELD_LINES = 313
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           regWe,
  input  logic [7:0]                     regWdata,
  input  logic                           regWmode,
  output logic [7:0]                     regRdata,
  output logic                           regRmode,
  output logic [$clog2(LINE_CLKS)-1:0]   pixCount,
  output lineStrobes_t                   strobes,
  output timingCfg_t                     activeCfg
);

  localparam int PIX_W  = $clog2(LINE_CLKS);
  localparam int LINE_W = $clog2(FRAME_LINES + 1);

  logic [PIX_W-1:0]  pixQ;
  logic [LINE_W-1:0] lineQ;
  timingByte_t       hostByte;
  logic              hostMode;
  timingCfg_t        cfgQ;
  logic              lineEnd;

  assign lineEnd = (pixQ == PIX_W'(LINE_CLKS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      pixQ     <= '0;
      lineQ    <= LINE_W'(1);
      hostByte <= '0;
      hostMode <= 1'b0;
      cfgQ     <= '0;
    end else begin
      pixQ <= lineEnd ? '0 : pixQ + 1'b1;
      if (lineEnd) begin
        lineQ <= (lineQ == LINE_W'(FRAME_LINES)) ? LINE_W'(1) : lineQ + 1'b1;
        // settings move to the sync logic only across a line boundary
        cfgQ  <= '{tb: hostByte, vsyncMode: hostMode};
      end
      if (regWe) begin
        hostByte <= timingByte_t'(regWdata);
        hostMode <= regWmode;
      end
    end
  end

  always_comb begin
    strobes.lineStart      = (pixQ == '0);
    strobes.firstEdgeLine  = (lineQ == LINE_W'(1));
    strobes.secondEdgeLine = (lineQ == LINE_W'(FIELD_LINES + 1));
    strobes.oddBody        = (lineQ > LINE_W'(1)) && (lineQ <= LINE_W'(FIELD_LINES));
  end

  assign pixCount  = pixQ;
  assign activeCfg = cfgQ;
  assign regRdata  = hostByte;
  assign regRmode  = hostMode;

endmodule

// File: rtl/vsg_dp.sv
module vsg_dp
  import vsg_pkg::*;
#(
  parameter int LINE_CLKS = 1728
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [$clog2(LINE_CLKS)-1:0] pixCount,
  input  lineStrobes_t                 strobes,
  input  timingCfg_t                   activeCfg,
  output logic                         hsyncN,
  output logic                         fvSync,
  output logic                         pixStrobe
);

  localparam int PIX_W = $clog2(LINE_CLKS);
  localparam int W     = PIX_W + 1;
  localparam int HALF  = LINE_CLKS / 2;

  logic [W-1:0] pixW, shiftW, hsEnd, edgeOff, fieldOff, vsEnd;
  logic         hsAct, fieldHigh, vsAct, edgeLine;

  always_comb begin
    pixW     = W'(pixCount);
    shiftW   = W'(activeCfg.tb.dataShift);
    hsEnd    = shiftW + W'(pulseCodeLen(activeCfg.tb.hsWidth));
    edgeOff  = shiftW + W'(delayCodeLen(activeCfg.tb.edgeDelay));
    fieldOff = edgeOff + (activeCfg.tb.fieldSel[0] ? W'(HALF) : '0);
    vsEnd    = edgeOff + W'(pulseCodeLen(activeCfg.tb.fieldSel));
    edgeLine = strobes.firstEdgeLine | strobes.secondEdgeLine;

    hsAct     = (pixW >= shiftW) && (pixW < hsEnd);
    fieldHigh = (strobes.firstEdgeLine && (pixW >= fieldOff)) ||
                strobes.oddBody ||
                (strobes.secondEdgeLine && (pixW < fieldOff));
    vsAct     = edgeLine && (pixW >= edgeOff) && (pixW < vsEnd);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hsyncN    <= 1'b1;
      fvSync    <= 1'b0;
      pixStrobe <= 1'b0;
    end else begin
      hsyncN    <= ~hsAct;
      fvSync    <= activeCfg.vsyncMode ? ~vsAct : fieldHigh;
      pixStrobe <= strobes.lineStart;
    end
  end

endmodule

// File: rtl/vsync_timing_gen.sv
module vsync_timing_gen
  import vsg_pkg::*;
#(
  parameter int LINE_CLKS   = 1728,
  parameter int FRAME_LINES = 625,
  parameter int FIELD_LINES = 313
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       regWe,
  input  logic [7:0] regWdata,
  input  logic       regWmode,
  output logic [7:0] regRdata,
  output logic       regRmode,
  output logic       hsyncN,
  output logic       fvSync,
  output logic       pixStrobe
);

  localparam int PIX_W = $clog2(LINE_CLKS);

  logic [PIX_W-1:0] pixCount;
  lineStrobes_t     strobes;
  timingCfg_t       activeCfg;

  vsg_ctrl #(
    .LINE_CLKS(LINE_CLKS), .FRAME_LINES(FRAME_LINES), .FIELD_LINES(FIELD_LINES)
  ) ctrl_i (
    .clk(clk), .rst(rst), .regWe(regWe), .regWdata(regWdata), .regWmode(regWmode),
    .regRdata(regRdata), .regRmode(regRmode), .pixCount(pixCount),
    .strobes(strobes), .activeCfg(activeCfg)
  );

  vsg_dp #(.LINE_CLKS(LINE_CLKS)) dp_i (
    .clk(clk), .rst(rst), .pixCount(pixCount), .strobes(strobes),
    .activeCfg(activeCfg), .hsyncN(hsyncN), .fvSync(fvSync), .pixStrobe(pixStrobe)
  );

endmodule

// File: rtl/vsg_checker.sv
module vsg_checker #(
  parameter int LINE_CLKS = 1728
) (
  input logic       clk,
  input logic       rst,
  input logic       regWe,
  input logic [7:0] regWdata,
  input logic       regWmode,
  input logic [7:0] regRdata,
  input logic       regRmode,
  input logic       hsyncN,
  input logic       pixStrobe
);

  localparam int PIX_W = $clog2(LINE_CLKS);

  logic [PIX_W-1:0] phase;
  logic [PIX_W:0]   lowRun;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= '0;
      lowRun <= '0;
    end else begin
      phase  <= (phase == PIX_W'(LINE_CLKS - 1)) ? '0 : phase + 1'b1;
      lowRun <= hsyncN ? '0 : lowRun + 1'b1;
    end
  end

  // R8: readback follows a write one edge later
  p_readback_r8: assert property (@(posedge clk) disable iff (rst)
    regWe |=> (regRdata == $past(regWdata)) && (regRmode == $past(regWmode)));

  // R8: no write, no change
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !regWe |=> $stable(regRdata) && $stable(regRmode));

  // R2: strobe exactly once per line period
  p_strobe_period_r2: assert property (@(posedge clk) disable iff (rst)
    pixStrobe == (phase == PIX_W'(1)));

  // R3: a finished low pulse has one of the four legal lengths
  p_hsync_width_r3: assert property (@(posedge clk) disable iff (rst)
    (hsyncN && lowRun != '0) |->
      (lowRun == 1 || lowRun == 4 || lowRun == 16 || lowRun == 128));

  // R4: the falling edge trails the strobe by 0 to 3 clocks
  p_hsync_shift_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(hsyncN) |-> (phase >= PIX_W'(1) && phase <= PIX_W'(4)));

endmodule

bind vsync_timing_gen vsg_checker #(.LINE_CLKS(LINE_CLKS)) chk_i (
  .clk(clk), .rst(rst), .regWe(regWe), .regWdata(regWdata), .regWmode(regWmode),
  .regRdata(regRdata), .regRmode(regRmode), .hsyncN(hsyncN), .pixStrobe(pixStrobe)
);

// File: tb/vsync_timing_gen_tb_top.sv
`timescale 1ns/1ps
module vsync_timing_gen_tb_top;

  localparam int L  = 320;
  localparam int F  = 11;
  localparam int FL = 6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       regWe = 1'b0;
  logic [7:0] regWdata = '0;
  logic       regWmode = 1'b0;
  logic [7:0] regRdata;
  logic       regRmode;
  logic       hsyncN, fvSync, pixStrobe;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // bench-side model state
  int         n = 0;
  logic [7:0] mReg = '0;
  bit         mMode = 0;
  logic [7:0] mCfg = '0;
  bit         mCfgMode = 0;

  always #2 clk = ~clk;

  vsync_timing_gen #(.LINE_CLKS(L), .FRAME_LINES(F), .FIELD_LINES(FL)) dut_i (
    .clk(clk), .rst(rst), .regWe(regWe), .regWdata(regWdata), .regWmode(regWmode),
    .regRdata(regRdata), .regRmode(regRmode), .hsyncN(hsyncN), .fvSync(fvSync),
    .pixStrobe(pixStrobe)
  );

  function automatic int lenCode(input logic [1:0] c);
    return (c == 0) ? 1 : (c == 1) ? 4 : (c == 2) ? 16 : 128;
  endfunction

  function automatic int dlyCode(input logic [1:0] c);
    return (c == 0) ? 0 : (c == 1) ? 4 : (c == 2) ? 8 : 16;
  endfunction

  function automatic void modelOut(input int pos, input logic [7:0] c, input bit m,
                                   output bit hs, output bit fv, output bit st);
    int pix, line, adj, off;
    pix  = pos % L;
    line = (pos / L) % F + 1;
    adj  = int'(c[7:6]);
    st   = (pix == 0);
    hs   = !(pix >= adj && pix < adj + lenCode(c[1:0]));
    if (!m) begin
      off = adj + dlyCode(c[3:2]) + (c[4] ? L / 2 : 0);
      fv  = (line == 1 && pix >= off) || (line > 1 && line <= FL) ||
            (line == FL + 1 && pix < off);
    end else begin
      off = adj + dlyCode(c[3:2]);
      fv  = !((line == 1 || line == FL + 1) && pix >= off &&
              pix < off + lenCode(c[5:4]));
    end
  endfunction

  task automatic check1(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s pos=%0d actual=%h expected=%h", tag, n, act, exp);
    end
  endtask

  // one clock: drive at negedge, edge n happens, check at next negedge
  task automatic cyc(input bit we, input logic [7:0] d, input bit m);
    bit eHs, eFv, eSt;
    regWe = we; regWdata = d; regWmode = m;
    @(posedge clk);
    @(negedge clk);
    modelOut(n, mCfg, mCfgMode, eHs, eFv, eSt);
    check1("R3 R4 R9 hsyncN", {7'd0, hsyncN}, {7'd0, eHs});
    check1(mCfgMode ? "R5 R7 R9 fvSync" : "R5 R6 R9 fvSync", {7'd0, fvSync}, {7'd0, eFv});
    check1("R2 pixStrobe", {7'd0, pixStrobe}, {7'd0, eSt});
    // R9: latch uses the register value from before this edge
    if ((n % L) == L - 1) begin
      mCfg = mReg; mCfgMode = mMode;
    end
    if (we) begin
      mReg = d; mMode = m;
    end
    check1("R8 regRdata", regRdata, mReg);
    check1("R8 regRmode", {7'd0, regRmode}, {7'd0, mMode});
    n++;
  endtask

  logic [8:0] dirList [8] = '{
    {8'h00, 1'b0}, {8'hFF, 1'b0}, {8'h1B, 1'b0}, {8'h3B, 1'b0},
    {8'h6E, 1'b1}, {8'hB1, 1'b1}, {8'hC7, 1'b1}, {8'h45, 1'b0}
  };

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd20240611);
    repeat (5) @(posedge clk);
    @(negedge clk);
    // R1: reset values
    check1("R1 hsyncN", {7'd0, hsyncN}, 8'd1);
    check1("R1 fvSync", {7'd0, fvSync}, 8'd0);
    check1("R1 pixStrobe", {7'd0, pixStrobe}, 8'd0);
    check1("R1 regRdata", regRdata, 8'd0);
    check1("R1 regRmode", {7'd0, regRmode}, 8'd0);
    rst = 1'b0;
    // R1 R2: first lines with defaults
    repeat (L + 7) cyc(0, '0, 0);
    // directed: each setting written mid-line, then held a full frame
    // (0x3B vs 0x1B shows byte bit 5 has no effect in field mode, R6)
    foreach (dirList[i]) begin
      repeat ($urandom % L) cyc(0, '0, 0);
      cyc(1, dirList[i][8:1], dirList[i][0]);
      repeat (F * L + 5) cyc(0, '0, 0);
    end
    // random writes at arbitrary pixels (R9)
    for (int k = 0; k < 40000; k++) begin
      if (($urandom % 300) == 0) cyc(1, 8'($urandom), 1'($urandom));
      else cyc(0, 8'($urandom), 1'($urandom));
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule